// File: doc/BRIEF.md
# Summary interrupt register

This block is the top of an interrupt hierarchy in a SONET/ATM line-interface device. Six lower-level interrupt registers (section, line, path, protection switching, receive cell and transmit cell) each report a single "something pending" flag. The block shows these flags as live bits in one status byte, next to an event bit that latches rising edges of an asynchronous one-second timing input. The host reads the byte to find which lower-level register to service next. The live bits clear only when that lower-level register is serviced. The timing-event bit clears when the summary byte itself is read.

A per-bit mask register and a one-bit event enable register sit at neighbouring addresses. The single interrupt output is the registered OR of the masked status bits. A parameter selects the LAN build, which forces the protection-switching bit to zero.

Top module: `irq_summary_reg`

## Requirements
- R1: In reset, the mask register reads 0x00, the enable register reads 0x00, the timing-event bit is 0 and `irq_o` is 0.
- R2: Reading address 0x3C returns the status byte with this layout: bit 0 section, bit 1 line, bit 2 path, bit 3 timing event, bit 4 reserved, bit 5 protection switching, bit 6 receive cell, bit 7 transmit cell. The `src_pend_i` index order is 0 section, 1 line, 2 path, 3 protection switching, 4 receive cell, 5 transmit cell. The live bits follow `src_pend_i` in the same cycle, with no latency.
- R3: A read strobe at 0x3C leaves the six live bits unchanged.
- R4: When enable bit 0 at 0x3A is 1, a 0-to-1 transition of `tick_i` sets status bit 3 on the third rising clock edge after the transition. A level held high after the bit is cleared does not set it again. Each new rising edge sets it again.
- R5: When enable bit 0 is 0, rising edges of `tick_i` leave bit 3 at 0.
- R6: A read strobe (`rd_en_i`) at 0x3C clears bit 3 at the clock edge that ends the read. A read strobe at any other address does not clear it.
- R7: If a rising timing edge reaches the latch in the same cycle as the clearing read, bit 3 stays set.
- R8: Bit 4 of the status byte always reads 0.
- R9: With `LAN_VARIANT`=1, bit 5 always reads 0 and cannot raise `irq_o`.
- R10: `irq_o` equals the OR over all bits of (status AND mask at 0x3B), taken one clock later. A mask bit of 1 enables its status bit.
- R11: The mask at 0x3B reads back all 8 bits written. The enable register at 0x3A reads back bit 0, with bits 7:1 reading 0. Writes to 0x3C are ignored. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (triggers clear-on-read) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| src_pend_i | input | 6 | Pending flags from the lower-level registers |
| tick_i | input | 1 | Asynchronous one-second timing input |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The bench sweeps all 256 masks against all 64 pending patterns on a standard build and a LAN build together. A wrong bit position, a live bit that is not forced in the LAN build, or a mask applied with the wrong polarity each shows up as a wrong status byte or a wrong interrupt level. Around the timing-event bit, the bench lines up a clearing read with an arriving edge in the same cycle. A design that gives the clear priority would lose that event. The bench also holds the timing input high after a clear, which catches a level-sensitive latch that sets the bit again. It reads other addresses and checks that the bit survives, which catches a decoder that clears on every read. Finally, it reads the summary while sources are pending, which exposes a design that wrongly clears the live bits on read.

// File: rtl/irq_summary_pkg.sv
package irq_summary_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_SRC = 6;

  // source index in src_pend_i
  localparam int SRC_SECTION = 0;
  localparam int SRC_LINE    = 1;
  localparam int SRC_PATH    = 2;
  localparam int SRC_APS     = 3;
  localparam int SRC_RXCELL  = 4;
  localparam int SRC_TXCELL  = 5;

  // bit position in the status byte
  localparam int BIT_SEC  = 0;
  localparam int BIT_LINE = 1;
  localparam int BIT_PATH = 2;
  localparam int BIT_TICK = 3;
  localparam int BIT_RSV  = 4;
  localparam int BIT_APS  = 5;
  localparam int BIT_RXC  = 6;
  localparam int BIT_TXC  = 7;

  function automatic int src_bit(input int idx);
    case (idx)
      SRC_SECTION: return BIT_SEC;
      SRC_LINE:    return BIT_LINE;
      SRC_PATH:    return BIT_PATH;
      SRC_APS:     return BIT_APS;
      SRC_RXCELL:  return BIT_RXC;
      default:     return BIT_TXC;
    endcase
  endfunction
endpackage

// File: rtl/irq_tick_sync.sv
module irq_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tick_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_event_bit.sv
module irq_event_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic en_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set wins over clear so a colliding event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_q <= 1'b0;
    else if (set_i && en_i)   q_q <= 1'b1;
    else if (clr_i)           q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_summary_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] SUM_ADDR  = 'h3C,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h3B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h3A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              tick_en_o,
  output logic              sum_rd_o
);
  logic [DATA_W-1:0] mask_q;
  logic              en_q;
  logic              hit_sum, hit_mask, hit_ctrl;

  assign hit_sum  = (addr_i == SUM_ADDR);
  assign hit_mask = (addr_i == MASK_ADDR);
  assign hit_ctrl = (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (hit_mask) mask_q <= wdata_i;
      if (hit_ctrl) en_q   <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_sum)       rdata_o = status_i;
    else if (hit_mask) rdata_o = mask_q;
    else if (hit_ctrl) rdata_o = {{(DATA_W-1){1'b0}}, en_q};
  end

  assign mask_o    = mask_q;
  assign tick_en_o = en_q;
  assign sum_rd_o  = rd_en_i & hit_sum;
endmodule

// File: rtl/irq_summary_reg.sv
module irq_summary_reg
  import irq_summary_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] SUM_ADDR    = 'h3C,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 'h3B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h3A,
  parameter bit                LAN_VARIANT = 1'b0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_pend_i,
  input  logic               tick_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_eff;
  logic [DATA_W-1:0]  status;
  logic [DATA_W-1:0]  mask;
  logic               tick_rise, tick_en, tick_q, sum_rd, irq_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (g == SRC_APS && LAN_VARIANT) begin : g_forced
      assign src_eff[g] = 1'b0;
    end else begin : g_live
      assign src_eff[g] = src_pend_i[g];
    end
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < NUM_SRC; i++) status[src_bit(i)] = src_eff[i];
    status[BIT_TICK] = tick_q;
  end

  irq_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rise_o (tick_rise)
  );

  irq_event_bit u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tick_rise),
    .en_i   (tick_en),
    .clr_i  (sum_rd),
    .q_o    (tick_q)
  );

  irq_reg_if #(
    .ADDR_W    (ADDR_W),
    .SUM_ADDR  (SUM_ADDR),
    .MASK_ADDR (MASK_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .wdata_i   (wdata_i),
    .status_i  (status),
    .rdata_o   (rdata_o),
    .mask_o    (mask),
    .tick_en_o (tick_en),
    .sum_rd_o  (sum_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status & mask);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_summary_chk.sv
module irq_summary_chk
  import irq_summary_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] SUM_ADDR    = 'h3C,
  parameter bit                LAN_VARIANT = 1'b0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               rd_en_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_SRC-1:0] src_pend_i,
  input logic [DATA_W-1:0]  status,
  input logic [DATA_W-1:0]  mask,
  input logic               irq_o,
  input logic               tick_rise,
  input logic               tick_en,
  input logic               tick_q
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SUM_ADDR) |-> !rdata_o[BIT_RSV]); // R8

  AST_LAN_APS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LAN_VARIANT && addr_i == SUM_ADDR) |-> !rdata_o[BIT_APS]); // R9

  AST_LIVE_SECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SUM_ADDR) |-> (rdata_o[BIT_SEC] == src_pend_i[SRC_SECTION])); // R2

  AST_IRQ_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status & mask)))); // R10

  AST_TICK_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_rise && tick_en) |=> tick_q); // R7

  AST_TICK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == SUM_ADDR && !(tick_rise && tick_en)) |=> !tick_q); // R6

  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(tick_rise && tick_en) && !(rd_en_i && addr_i == SUM_ADDR)) |=> $stable(tick_q)); // R5
endmodule

bind irq_summary_reg irq_summary_chk #(
  .ADDR_W      (ADDR_W),
  .SUM_ADDR    (SUM_ADDR),
  .LAN_VARIANT (LAN_VARIANT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_en_i    (rd_en_i),
  .rdata_o    (rdata_o),
  .src_pend_i (src_pend_i),
  .status     (status),
  .mask       (mask),
  .irq_o      (irq_o),
  .tick_rise  (tick_rise),
  .tick_en    (tick_en),
  .tick_q     (tick_q)
);

// File: tb/sim_irq_summary_reg.sv
`timescale 1ns/1ps
module sim_irq_summary_reg;
  localparam logic [7:0] A_SUM  = 8'h3C;
  localparam logic [7:0] A_MASK = 8'h3B;
  localparam logic [7:0] A_CTRL = 8'h3A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = A_MASK;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [5:0] pend = 6'h00;
  logic       tick = 1'b0;
  logic [7:0] rdata0, rdata1;
  logic       irq0, irq1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_summary_reg #(.LAN_VARIANT(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata0), .src_pend_i(pend), .tick_i(tick), .irq_o(irq0));

  irq_summary_reg #(.LAN_VARIANT(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata1), .src_pend_i(pend), .tick_i(tick), .irq_o(irq1));

  // status byte from R2/R8/R9 layout
  function automatic logic [7:0] exp_sum(input logic [5:0] p, input logic t, input bit lan);
    return {p[5], p[4], p[3] & ~lan, 1'b0, t, p[2], p[1], p[0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a);
    addr = a;
    #1;
  endtask

  task automatic rd_strobe(input logic [7:0] a);
    addr = a; rd_en = 1'b1;
    step(1);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state with sources pending
    pend = 6'h3F;
    #25;
    peek(A_MASK); chk("R1 mask", rdata0, 8'h00);
    peek(A_CTRL); chk("R1 enable", rdata0, 8'h00);
    chk("R1 irq", {7'b0, irq0}, 8'h00);
    peek(A_SUM);  chk("R1 tick bit", {7'b0, rdata0[3]}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    pend = 6'h00;
    step(1);

    // R11: register access
    wr(A_MASK, 8'hA5);
    peek(A_MASK); chk("R11 mask rb", rdata0, 8'hA5);
    wr(A_CTRL, 8'hFF);
    peek(A_CTRL); chk("R11 enable rb", rdata0, 8'h01);
    peek(8'h00);  chk("R11 unmapped", rdata0, 8'h00);
    wr(A_SUM, 8'hFF);
    peek(A_SUM);  chk("R11 write to status ignored", rdata0, 8'h00);
    peek(A_MASK); chk("R11 mask kept", rdata0, 8'hA5);

    // R2 R8 R9 R10: exhaustive mask x pending sweep
    for (int m = 0; m < 256; m++) begin
      wr(A_MASK, 8'(m));
      for (int p = 0; p < 64; p++) begin
        pend = 6'(p);
        peek(A_SUM);
        chk("R2 R8 status", rdata0, exp_sum(6'(p), 1'b0, 1'b0));
        chk("R9 lan status", rdata1, exp_sum(6'(p), 1'b0, 1'b1));
        step(1);
        chk("R10 irq", {7'b0, irq0}, {7'b0, |(exp_sum(6'(p), 1'b0, 1'b0) & 8'(m))});
        chk("R9 R10 lan irq", {7'b0, irq1}, {7'b0, |(exp_sum(6'(p), 1'b0, 1'b1) & 8'(m))});
      end
    end

    // R3: read strobe keeps live bits
    pend = 6'h3F;
    addr = A_SUM; rd_en = 1'b1; #1;
    chk("R3 during read", rdata0, exp_sum(6'h3F, 1'b0, 1'b0));
    step(1);
    rd_en = 1'b0;
    peek(A_SUM);
    chk("R3 after read", rdata0, exp_sum(6'h3F, 1'b0, 1'b0));
    pend = 6'h00;

    // R4: edge sets bit 3 on third edge
    wr(A_MASK, 8'h08);
    tick = 1'b1;
    step(2);
    peek(A_SUM); chk("R4 not yet", rdata0, 8'h00);
    step(1);
    peek(A_SUM); chk("R4 set", rdata0, 8'h08);
    step(1);
    chk("R10 irq from tick", {7'b0, irq0}, 8'h01);

    // R6: clear on read, R4: held level does not retrigger
    rd_strobe(A_SUM);
    peek(A_SUM); chk("R6 cleared", rdata0, 8'h00);
    step(4);
    peek(A_SUM); chk("R4 no retrigger", rdata0, 8'h00);
    chk("R10 irq low", {7'b0, irq0}, 8'h00);

    // R4 new edge, R6 other address read keeps bit
    tick = 1'b0; step(3);
    tick = 1'b1; step(3);
    peek(A_SUM); chk("R4 new edge", rdata0, 8'h08);
    rd_strobe(A_MASK);
    peek(A_SUM); chk("R6 other addr keeps", rdata0, 8'h08);
    rd_strobe(A_SUM);
    peek(A_SUM); chk("R6 cleared again", rdata0, 8'h00);

    // R5: disabled edges ignored
    wr(A_CTRL, 8'h00);
    tick = 1'b0; step(3);
    tick = 1'b1; step(4);
    peek(A_SUM); chk("R5 disabled", rdata0, 8'h00);
    chk("R5 irq", {7'b0, irq0}, 8'h00);
    wr(A_CTRL, 8'h01);

    // R7: edge lands with clearing read
    tick = 1'b0; step(3);
    tick = 1'b1; step(2);
    addr = A_SUM; rd_en = 1'b1;
    step(1);
    rd_en = 1'b0;
    peek(A_SUM); chk("R7 set wins", rdata0, 8'h08);
    rd_strobe(A_SUM);
    peek(A_SUM); chk("R7 later clear", rdata0, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule